// File: doc/BRIEF.md
# Split Register Rename Map Table

This block keeps the speculative mapping from architectural register numbers to physical register tags in an out-of-order core. One architectural index space is split into three ranges: the low range selects the integer map, the middle range selects the floating-point map, and every index above both selects a miscellaneous register. Miscellaneous registers are never renamed. Each one owns a fixed physical tag in a window placed above all renamable physical registers.

The rename port takes a new tag from the integer or floating-point free list and writes it into the map entry. It returns both the new tag and the tag the entry held before. If the free list of the needed class is empty, the port stalls. The lookup port reads the registered map combinationally. The direct-set port writes one entry during recovery. A binding strobe loads every integer entry and every floating-point entry with consecutive tags, each class counting up from its own base. The block also reports how many renames can still be taken: the smaller of the two free-list counts.

Top module: `rename_map_table`

## Requirements
- R1: After reset, integer entry i holds tag i, and floating-point entry j (architectural index NUM_INT_LOG+j) holds tag NUM_INT_PHYS+j.
- R2: The lookup port returns the registered mapping for integer and floating-point indices. For a miscellaneous index a, it returns a - (NUM_INT_LOG+NUM_FP_LOG) + (NUM_INT_PHYS+NUM_FP_PHYS).
- R3: An accepted rename of a non-zero integer or floating-point index returns the tag offered by that class's free list as the new tag and the entry's current tag as the previous tag. It pops only that free list and writes the new tag into the entry at the clock edge. A lookup of the same index in the same cycle returns the old tag.
- R4: Renaming the integer zero index (default 0) or the floating-point zero index (default NUM_INT_LOG) returns that index as the new tag and the entry's current tag as the previous tag. It pops nothing, leaves the map unchanged and never stalls because a free list is empty.
- R5: Renaming a miscellaneous index returns its pass-through tag as both the new and the previous tag. It pops nothing and does not stall.
- R6: The direct-set port writes an integer or floating-point entry. A write aimed at a miscellaneous index changes no entry. If a direct-set and a rename write the same entry in one cycle, the direct-set value is the one stored.
- R7: While the binding strobe is high, each integer entry i is loaded with int_base+i and each floating-point entry j with fp_base+j. Any rename request in that cycle stalls.
- R8: A rename that needs a tag from an empty free list asserts the stall output, pops nothing and leaves the map unchanged.
- R9: The free_slots output equals the smaller of the integer and floating-point free counts.
- R10: Every tag taken from the integer free list lies below NUM_INT_PHYS. Every tag taken from the floating-point free list lies in [NUM_INT_PHYS, NUM_INT_PHYS+NUM_FP_PHYS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bind_en | input | 1 | Load all integer and floating-point entries from the bases |
| bind_int_base | input | TAG_W | First tag given to integer entry 0 during binding |
| bind_fp_base | input | TAG_W | First tag given to floating-point entry 0 during binding |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | ARCH_W | Architectural index to rename |
| ren_new_tag | output | TAG_W | Tag that now backs the index |
| ren_prev_tag | output | TAG_W | Tag the index held before the rename |
| ren_stall | output | 1 | Request not taken this cycle |
| lk_arch | input | ARCH_W | Architectural index to look up |
| lk_tag | output | TAG_W | Current tag of lk_arch |
| set_valid | input | 1 | Direct-set write strobe |
| set_arch | input | ARCH_W | Architectural index to overwrite |
| set_tag | input | TAG_W | Tag to store |
| int_fl_empty | input | 1 | Integer free list has no tag |
| int_fl_tag | input | TAG_W | Tag at the head of the integer free list |
| int_fl_count | input | CNT_W | Number of free integer tags |
| int_fl_pop | output | 1 | Take the integer head tag |
| fp_fl_empty | input | 1 | Floating-point free list has no tag |
| fp_fl_tag | input | TAG_W | Tag at the head of the floating-point free list |
| fp_fl_count | input | CNT_W | Number of free floating-point tags |
| fp_fl_pop | output | 1 | Take the floating-point head tag |
| free_slots | output | CNT_W | Renames that can still be taken |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a rename and a lookup name the same index. The table vector drives both ports together, and the lookup must return the old tag while the rename reports the new one. The next vector then sees the new tag on the lookup port. In the second, a rename and a direct-set hit the same entry together. The rename must still return the free-list tag, and the following lookup must show the direct-set value. Zero-index and miscellaneous renames are interleaved with normal ones. The tag the next normal rename receives then shows that no free-list entry was consumed by them.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } reg_class_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rename_map_decode.sv
module rename_map_decode
  import rename_map_pkg::*;
#(
  parameter int unsigned NUM_INT_LOG  = 8,
  parameter int unsigned NUM_FP_LOG   = 8,
  parameter int unsigned NUM_PHYS     = 32,
  parameter int unsigned INT_ZERO_IDX = 0,
  parameter int unsigned FP_ZERO_IDX  = 8,
  parameter int unsigned ARCH_W       = 5,
  parameter int unsigned IDX_W        = 3,
  parameter int unsigned TAG_W        = 6
) (
  input  logic [ARCH_W-1:0] arch,
  output reg_class_e        cls,
  output logic [IDX_W-1:0]  local_idx,
  output logic [TAG_W-1:0]  misc_tag,
  output logic              is_zero
);
  localparam int unsigned NUM_LOG = NUM_INT_LOG + NUM_FP_LOG;
  localparam logic [ARCH_W-1:0] INT_END = ARCH_W'(NUM_INT_LOG);
  localparam logic [ARCH_W-1:0] LOG_END = ARCH_W'(NUM_LOG);

  logic [ARCH_W-1:0] fp_off;
  logic [ARCH_W-1:0] misc_off;

  assign fp_off   = arch - INT_END;
  assign misc_off = arch - LOG_END;

  always_comb begin
    if (arch < INT_END) begin
      cls       = CLS_INT;
      local_idx = IDX_W'(arch);
      is_zero   = (arch == ARCH_W'(INT_ZERO_IDX));
    end else if (arch < LOG_END) begin
      cls       = CLS_FP;
      local_idx = IDX_W'(fp_off);
      is_zero   = (arch == ARCH_W'(FP_ZERO_IDX));
    end else begin
      cls       = CLS_MISC;
      local_idx = '0;
      is_zero   = 1'b0;
    end
  end

  assign misc_tag = TAG_W'(misc_off) + TAG_W'(NUM_PHYS);
endmodule

// File: rtl/rename_map_bank.sv
module rename_map_bank #(
  parameter int unsigned ENTRIES  = 8,
  parameter int unsigned RST_BASE = 0,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned TAG_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bind_en,
  input  logic [TAG_W-1:0] bind_base,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             ren_en,
  input  logic [IDX_W-1:0] ren_idx,
  input  logic [TAG_W-1:0] ren_tag,
  input  logic [IDX_W-1:0] rd0_idx,
  output logic [TAG_W-1:0] rd0_tag,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic [TAG_W-1:0] rd1_tag
);
  logic [TAG_W-1:0] map_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [TAG_W-1:0] ent_q;
    logic [TAG_W-1:0] ent_d;
    logic             ent_en;
    logic             set_hit;
    logic             ren_hit;

    assign set_hit = set_en && (set_idx == IDX_W'(e));
    assign ren_hit = ren_en && (ren_idx == IDX_W'(e));
    assign ent_en  = bind_en || set_hit || ren_hit;

    // Priority: binding, then recovery write, then rename.
    always_comb begin
      if (bind_en)      ent_d = bind_base + TAG_W'(e);
      else if (set_hit) ent_d = set_tag;
      else              ent_d = ren_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= TAG_W'(RST_BASE + e);
      else if (ent_en) ent_q <= ent_d;
    end

    assign map_q[e] = ent_q;
  end

  assign rd0_tag = (int'(rd0_idx) < ENTRIES) ? map_q[rd0_idx] : '0;
  assign rd1_tag = (int'(rd1_idx) < ENTRIES) ? map_q[rd1_idx] : '0;
endmodule

// File: rtl/rename_map_alloc.sv
module rename_map_alloc
  import rename_map_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             ren_valid,
  input  reg_class_e       ren_cls,
  input  logic             ren_zero,
  input  logic             bind_en,
  input  logic             int_fl_empty,
  input  logic             fp_fl_empty,
  input  logic [CNT_W-1:0] int_fl_count,
  input  logic [CNT_W-1:0] fp_fl_count,
  output logic             int_take,
  output logic             fp_take,
  output logic             stall,
  output logic [CNT_W-1:0] free_slots
);
  logic needs_int;
  logic needs_fp;
  logic starved;

  assign needs_int = ren_valid && !ren_zero && (ren_cls == CLS_INT);
  assign needs_fp  = ren_valid && !ren_zero && (ren_cls == CLS_FP);
  assign starved   = (needs_int && int_fl_empty) || (needs_fp && fp_fl_empty);

  assign stall    = ren_valid && (bind_en || starved);
  assign int_take = needs_int && !stall;
  assign fp_take  = needs_fp && !stall;

  assign free_slots = (int_fl_count < fp_fl_count) ? int_fl_count : fp_fl_count;
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_map_pkg::*;
#(
  parameter int unsigned NUM_INT_LOG  = 8,
  parameter int unsigned NUM_FP_LOG   = 8,
  parameter int unsigned NUM_INT_PHYS = 16,
  parameter int unsigned NUM_FP_PHYS  = 16,
  parameter int unsigned NUM_MISC     = 4,
  parameter int unsigned INT_ZERO_IDX = 0,
  parameter int unsigned FP_ZERO_IDX  = NUM_INT_LOG,
  parameter int unsigned ARCH_W       = width_of(NUM_INT_LOG + NUM_FP_LOG + NUM_MISC),
  parameter int unsigned TAG_W        = width_of(NUM_INT_PHYS + NUM_FP_PHYS + NUM_MISC),
  parameter int unsigned CNT_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bind_en,
  input  logic [TAG_W-1:0]  bind_int_base,
  input  logic [TAG_W-1:0]  bind_fp_base,
  input  logic              ren_valid,
  input  logic [ARCH_W-1:0] ren_arch,
  output logic [TAG_W-1:0]  ren_new_tag,
  output logic [TAG_W-1:0]  ren_prev_tag,
  output logic              ren_stall,
  input  logic [ARCH_W-1:0] lk_arch,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              set_valid,
  input  logic [ARCH_W-1:0] set_arch,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic              int_fl_empty,
  input  logic [TAG_W-1:0]  int_fl_tag,
  input  logic [CNT_W-1:0]  int_fl_count,
  output logic              int_fl_pop,
  input  logic              fp_fl_empty,
  input  logic [TAG_W-1:0]  fp_fl_tag,
  input  logic [CNT_W-1:0]  fp_fl_count,
  output logic              fp_fl_pop,
  output logic [CNT_W-1:0]  free_slots
);
  localparam int unsigned NUM_PHYS = NUM_INT_PHYS + NUM_FP_PHYS;
  localparam int unsigned MAX_LOG  = (NUM_INT_LOG > NUM_FP_LOG) ? NUM_INT_LOG : NUM_FP_LOG;
  localparam int unsigned IDX_W    = width_of(MAX_LOG);
  localparam int unsigned NPORT    = 3;  // 0: rename, 1: lookup, 2: direct-set

  reg_class_e        p_cls  [NPORT];
  logic [IDX_W-1:0]  p_idx  [NPORT];
  logic [TAG_W-1:0]  p_misc [NPORT];
  logic              p_zero [NPORT];
  logic [ARCH_W-1:0] p_arch [NPORT];

  assign p_arch[0] = ren_arch;
  assign p_arch[1] = lk_arch;
  assign p_arch[2] = set_arch;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    rename_map_decode #(
      .NUM_INT_LOG (NUM_INT_LOG),
      .NUM_FP_LOG  (NUM_FP_LOG),
      .NUM_PHYS    (NUM_PHYS),
      .INT_ZERO_IDX(INT_ZERO_IDX),
      .FP_ZERO_IDX (FP_ZERO_IDX),
      .ARCH_W      (ARCH_W),
      .IDX_W       (IDX_W),
      .TAG_W       (TAG_W)
    ) u_dec (
      .arch     (p_arch[p]),
      .cls      (p_cls[p]),
      .local_idx(p_idx[p]),
      .misc_tag (p_misc[p]),
      .is_zero  (p_zero[p])
    );
  end

  logic int_take;
  logic fp_take;

  rename_map_alloc #(.CNT_W(CNT_W)) u_alloc (
    .ren_valid   (ren_valid),
    .ren_cls     (p_cls[0]),
    .ren_zero    (p_zero[0]),
    .bind_en     (bind_en),
    .int_fl_empty(int_fl_empty),
    .fp_fl_empty (fp_fl_empty),
    .int_fl_count(int_fl_count),
    .fp_fl_count (fp_fl_count),
    .int_take    (int_take),
    .fp_take     (fp_take),
    .stall       (ren_stall),
    .free_slots  (free_slots)
  );

  assign int_fl_pop = int_take;
  assign fp_fl_pop  = fp_take;

  logic int_set_en;
  logic fp_set_en;
  logic [TAG_W-1:0] int_rd_ren;
  logic [TAG_W-1:0] int_rd_lk;
  logic [TAG_W-1:0] fp_rd_ren;
  logic [TAG_W-1:0] fp_rd_lk;

  assign int_set_en = set_valid && (p_cls[2] == CLS_INT);
  assign fp_set_en  = set_valid && (p_cls[2] == CLS_FP);

  rename_map_bank #(
    .ENTRIES (NUM_INT_LOG),
    .RST_BASE(0),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W)
  ) u_int_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bind_en  (bind_en),
    .bind_base(bind_int_base),
    .set_en   (int_set_en),
    .set_idx  (p_idx[2]),
    .set_tag  (set_tag),
    .ren_en   (int_take),
    .ren_idx  (p_idx[0]),
    .ren_tag  (int_fl_tag),
    .rd0_idx  (p_idx[0]),
    .rd0_tag  (int_rd_ren),
    .rd1_idx  (p_idx[1]),
    .rd1_tag  (int_rd_lk)
  );

  rename_map_bank #(
    .ENTRIES (NUM_FP_LOG),
    .RST_BASE(NUM_INT_PHYS),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W)
  ) u_fp_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bind_en  (bind_en),
    .bind_base(bind_fp_base),
    .set_en   (fp_set_en),
    .set_idx  (p_idx[2]),
    .set_tag  (set_tag),
    .ren_en   (fp_take),
    .ren_idx  (p_idx[0]),
    .ren_tag  (fp_fl_tag),
    .rd0_idx  (p_idx[0]),
    .rd0_tag  (fp_rd_ren),
    .rd1_idx  (p_idx[1]),
    .rd1_tag  (fp_rd_lk)
  );

  always_comb begin
    unique case (p_cls[0])
      CLS_INT: begin
        ren_prev_tag = int_rd_ren;
        ren_new_tag  = p_zero[0] ? TAG_W'(INT_ZERO_IDX) : int_fl_tag;
      end
      CLS_FP: begin
        ren_prev_tag = fp_rd_ren;
        ren_new_tag  = p_zero[0] ? TAG_W'(FP_ZERO_IDX) : fp_fl_tag;
      end
      default: begin
        ren_prev_tag = p_misc[0];
        ren_new_tag  = p_misc[0];
      end
    endcase
  end

  always_comb begin
    unique case (p_cls[1])
      CLS_INT: lk_tag = int_rd_lk;
      CLS_FP:  lk_tag = fp_rd_lk;
      default: lk_tag = p_misc[1];
    endcase
  end
endmodule

// File: rtl/rename_map_table_chk.sv
module rename_map_table_chk #(
  parameter int unsigned NUM_INT_LOG  = 8,
  parameter int unsigned NUM_FP_LOG   = 8,
  parameter int unsigned NUM_INT_PHYS = 16,
  parameter int unsigned NUM_FP_PHYS  = 16,
  parameter int unsigned ARCH_W       = 5,
  parameter int unsigned TAG_W        = 6,
  parameter int unsigned CNT_W        = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bind_en,
  input logic              ren_valid,
  input logic [ARCH_W-1:0] ren_arch,
  input logic [TAG_W-1:0]  ren_new_tag,
  input logic [TAG_W-1:0]  ren_prev_tag,
  input logic              ren_stall,
  input logic              int_fl_empty,
  input logic [TAG_W-1:0]  int_fl_tag,
  input logic [CNT_W-1:0]  int_fl_count,
  input logic              int_fl_pop,
  input logic              fp_fl_empty,
  input logic [TAG_W-1:0]  fp_fl_tag,
  input logic [CNT_W-1:0]  fp_fl_count,
  input logic              fp_fl_pop,
  input logic [CNT_W-1:0]  free_slots
);
  localparam int unsigned NUM_LOG  = NUM_INT_LOG + NUM_FP_LOG;
  localparam int unsigned NUM_PHYS = NUM_INT_PHYS + NUM_FP_PHYS;

  a_r8_stall_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |-> (!int_fl_pop && !fp_fl_pop));

  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fl_empty |-> !int_fl_pop) and (fp_fl_empty |-> !fp_fl_pop));

  a_r3_one_class_popped: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_fl_pop, fp_fl_pop}));

  a_r3_pop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fl_pop || fp_fl_pop) |-> (ren_valid && !ren_stall));

  a_r10_int_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    int_fl_pop |-> (int'(int_fl_tag) < NUM_INT_PHYS));

  a_r10_fp_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    fp_fl_pop |-> (int'(fp_fl_tag) >= NUM_INT_PHYS && int'(fp_fl_tag) < NUM_PHYS));

  a_r5_misc_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !bind_en && int'(ren_arch) >= NUM_LOG) |->
      (ren_new_tag == ren_prev_tag && !ren_stall && !int_fl_pop && !fp_fl_pop));

  a_r7_bind_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (bind_en && ren_valid) |-> ren_stall);

  a_r9_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots <= int_fl_count) && (free_slots <= fp_fl_count) &&
    ((free_slots == int_fl_count) || (free_slots == fp_fl_count)));
endmodule

bind rename_map_table rename_map_table_chk #(
  .NUM_INT_LOG (NUM_INT_LOG),
  .NUM_FP_LOG  (NUM_FP_LOG),
  .NUM_INT_PHYS(NUM_INT_PHYS),
  .NUM_FP_PHYS (NUM_FP_PHYS),
  .ARCH_W      (ARCH_W),
  .TAG_W       (TAG_W),
  .CNT_W       (CNT_W)
) u_chk (.*);

// File: tb/test_rename_map_table.sv
`timescale 1ns/1ps
module test_rename_map_table;
  localparam int AW = 5;
  localparam int TW = 6;
  localparam int CW = 6;
  localparam int INT_DEPTH = 4;  // stub tags 8..11
  localparam int FP_DEPTH  = 3;  // stub tags 24..26

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          bind_en;
  logic [TW-1:0] bind_int_base, bind_fp_base;
  logic          ren_valid;
  logic [AW-1:0] ren_arch;
  logic [TW-1:0] ren_new_tag, ren_prev_tag;
  logic          ren_stall;
  logic [AW-1:0] lk_arch;
  logic [TW-1:0] lk_tag;
  logic          set_valid;
  logic [AW-1:0] set_arch;
  logic [TW-1:0] set_tag;
  logic          int_fl_empty, fp_fl_empty, int_fl_pop, fp_fl_pop;
  logic [TW-1:0] int_fl_tag, fp_fl_tag;
  logic [CW-1:0] int_fl_count, fp_fl_count, free_slots;

  // Free-list stubs: FIFOs of consecutive tags.
  int int_head = 0;
  int fp_head  = 0;
  assign int_fl_empty = (int_head >= INT_DEPTH);
  assign fp_fl_empty  = (fp_head >= FP_DEPTH);
  assign int_fl_tag   = TW'(8 + int_head);
  assign fp_fl_tag    = TW'(24 + fp_head);
  assign int_fl_count = CW'(INT_DEPTH - int_head);
  assign fp_fl_count  = CW'(FP_DEPTH - fp_head);
  always @(posedge clk) begin
    if (int_fl_pop) int_head <= int_head + 1;
    if (fp_fl_pop)  fp_head  <= fp_head + 1;
  end

  rename_map_table i_rename_map_table (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic          rv;
    logic [AW-1:0] ra;
    logic          sv;
    logic [AW-1:0] sa;
    logic [TW-1:0] st;
    logic [AW-1:0] la;
    logic [TW-1:0] elk;
    logic [TW-1:0] en;
    logic [TW-1:0] ep;
    logic          es;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd3,  6'd3,  6'd0,  6'd0,  1'b0, 4'd2},  // R2 int
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd10, 6'd18, 6'd0,  6'd0,  1'b0, 4'd2},  // R2 fp
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd17, 6'd33, 6'd0,  6'd0,  1'b0, 4'd2},  // R2 misc
    '{1'b1, 5'd3,  1'b0, 5'd0,  6'd0,  5'd3,  6'd3,  6'd8,  6'd3,  1'b0, 4'd3},  // R3 same-cycle lookup old
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd3,  6'd8,  6'd0,  6'd0,  1'b0, 4'd3},
    '{1'b1, 5'd3,  1'b0, 5'd0,  6'd0,  5'd0,  6'd0,  6'd9,  6'd8,  1'b0, 4'd3},
    '{1'b1, 5'd0,  1'b0, 5'd0,  6'd0,  5'd3,  6'd9,  6'd0,  6'd0,  1'b0, 4'd4},  // R4 int zero
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd0,  6'd0,  6'd0,  6'd0,  1'b0, 4'd4},
    '{1'b1, 5'd9,  1'b0, 5'd0,  6'd0,  5'd9,  6'd17, 6'd24, 6'd17, 1'b0, 4'd3},  // R3 fp
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd9,  6'd24, 6'd0,  6'd0,  1'b0, 4'd3},
    '{1'b1, 5'd8,  1'b0, 5'd0,  6'd0,  5'd8,  6'd16, 6'd8,  6'd16, 1'b0, 4'd4},  // R4 fp zero
    '{1'b1, 5'd18, 1'b0, 5'd0,  6'd0,  5'd8,  6'd16, 6'd34, 6'd34, 1'b0, 4'd5},  // R5 misc
    '{1'b1, 5'd4,  1'b1, 5'd5,  6'd14, 5'd5,  6'd5,  6'd10, 6'd4,  1'b0, 4'd6},  // R6 set + R4 no pop
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd5,  6'd14, 6'd0,  6'd0,  1'b0, 4'd6},
    '{1'b0, 5'd0,  1'b1, 5'd19, 6'd7,  5'd19, 6'd35, 6'd0,  6'd0,  1'b0, 4'd6},  // R6 misc set ignored
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd3,  6'd9,  6'd0,  6'd0,  1'b0, 4'd6},
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd11, 6'd19, 6'd0,  6'd0,  1'b0, 4'd6},
    '{1'b0, 5'd0,  1'b1, 5'd12, 6'd30, 5'd12, 6'd20, 6'd0,  6'd0,  1'b0, 4'd6},  // R6 fp set
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd12, 6'd30, 6'd0,  6'd0,  1'b0, 4'd6},
    '{1'b1, 5'd4,  1'b1, 5'd4,  6'd13, 5'd4,  6'd10, 6'd11, 6'd10, 1'b0, 4'd6},  // R6 set beats rename
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd4,  6'd13, 6'd0,  6'd0,  1'b0, 4'd6},
    '{1'b1, 5'd6,  1'b0, 5'd0,  6'd0,  5'd6,  6'd6,  6'd0,  6'd0,  1'b1, 4'd8},  // R8 int empty
    '{1'b0, 5'd0,  1'b0, 5'd0,  6'd0,  5'd6,  6'd6,  6'd0,  6'd0,  1'b0, 4'd8}
  };

  task automatic idle();
    bind_en = 1'b0; ren_valid = 1'b0; set_valid = 1'b0;
    ren_arch = '0; set_arch = '0; set_tag = '0; lk_arch = '0;
    bind_int_base = '0; bind_fp_base = '0;
  endtask

  task automatic do_ren(input int a, input int en, input int ep, input int es, input string rq);
    @(negedge clk);
    idle();
    ren_valid = 1'b1; ren_arch = AW'(a);
    #1;
    check(rq, int'(ren_stall), es);
    if (es == 0) begin
      check(rq, int'(ren_new_tag), en);
      check(rq, int'(ren_prev_tag), ep);
    end
  endtask

  task automatic do_lk(input int a, input int exp, input string rq);
    @(negedge clk);
    idle();
    lk_arch = AW'(a);
    #1;
    check(rq, int'(lk_tag), exp);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset mapping, R9 initial minimum
    lk_arch = AW'(5);  #1; check("R1", int'(lk_tag), 5);
    lk_arch = AW'(13); #1; check("R1", int'(lk_tag), 21);
    check("R9", int'(free_slots), 3);
    check("R8", int'(ren_stall), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ren_valid = VEC[i].rv; ren_arch = VEC[i].ra;
      set_valid = VEC[i].sv; set_arch = VEC[i].sa; set_tag = VEC[i].st;
      lk_arch = VEC[i].la;
      #1;
      check($sformatf("R%0d vec%0d lookup", VEC[i].rq, i), int'(lk_tag), int'(VEC[i].elk));
      if (VEC[i].rv) begin
        check($sformatf("R%0d vec%0d stall", VEC[i].rq, i), int'(ren_stall), int'(VEC[i].es));
        if (!VEC[i].es) begin
          check($sformatf("R%0d vec%0d new", VEC[i].rq, i), int'(ren_new_tag), int'(VEC[i].en));
          check($sformatf("R%0d vec%0d prev", VEC[i].rq, i), int'(ren_prev_tag), int'(VEC[i].ep));
        end
      end
    end

    @(negedge clk); idle(); #1;
    check("R9", int'(free_slots), 0);

    // R3 / R8: floating-point list runs dry
    do_ren(13, 25, 21, 0, "R3");
    do_ren(14, 26, 22, 0, "R3");
    do_ren(15, 0, 0, 1, "R8");
    do_lk(15, 23, "R8");
    // R4: zero index never stalls with both lists empty
    do_ren(0, 0, 0, 0, "R4");
    do_ren(8, 8, 16, 0, "R4");

    // R7 binding, rename during binding stalls
    @(negedge clk);
    idle();
    bind_en = 1'b1; bind_int_base = TW'(4); bind_fp_base = TW'(20);
    ren_valid = 1'b1; ren_arch = AW'(3);
    #1;
    check("R7", int'(ren_stall), 1);
    do_lk(2, 6, "R7");
    do_lk(10, 22, "R7");
    do_lk(3, 7, "R7");
    do_lk(17, 33, "R7");

    // R1 reset restores mapping
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    lk_arch = AW'(4); #1; check("R1", int'(lk_tag), 4);
    lk_arch = AW'(12); #1; check("R1", int'(lk_tag), 20);
    @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule